// File: doc/BRIEF.md
# Carry-Selected Dual-Result Byte ALU

This block is a purely combinational 8-bit arithmetic and logic unit. It is organised the way a precomputed lookup-table ALU is organised. For every operation it forms two candidate bytes at the same time. The pair is either a "link clear" and a "link set" variant of one function, or the low and high halves of a 16-bit answer.

An incoming link/carry bit never ripples into an adder. It only picks one of the two finished bytes. The caller can take both bytes as a 16-bit pair, or take a single byte selected by the link.

Operations are chosen by a 4-bit code. They cover:
- add and subtract, with and without carry or borrow
- an unsigned 8×8 multiply
- unsigned min/max
- four byte-wide logic functions
- a 16-bit word increment and decrement, usable as a program-counter step
- one-bit shifts through the link

Top module: `dual_result_alu`

## Requirements
- R1: With `pair_mode`=1, `res_pair` carries the high candidate in bits [15:8] and the low candidate in bits [7:0]. With `pair_mode`=0, `res_pair` is `{8'h00, res_sel}`.
- R2: In both modes `res_sel` equals the high candidate when `link`=1 and the low candidate when `link`=0.
- R3: Code 0 (add): low = (A+B) mod 256, high = (A+B+1) mod 256.
- R4: Code 1 (subtract): low = (A−B) mod 256, high = (A−B−1) mod 256.
- R5: Code 2 (multiply): {high, low} is the unsigned 16-bit product A×B.
- R6: Code 3 (min/max): low is the smaller and high the larger of A and B, both unsigned.
- R7: Code 4 gives low = A OR B and high = A XOR B. Code 5 gives low = NOR(A, B) and high = A AND B.
- R8: Codes 6 and 7 treat {B, A} as one 16-bit word, with B as the high byte. Code 6 returns word+1 and code 7 returns word−1, modulo 2^16, with the high byte in the high candidate.
- R9: Code 8 shifts A left by one, shifting in 0 (low) or 1 (high). Code 9 shifts A right by one, shifting in 0 (low) or 1 (high) at bit 7.
- R10: Codes 10 to 15 give zero in both candidates, so both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opa | input | 8 | Operand A (low byte for word operations) |
| opb | input | 8 | Operand B (high byte for word operations) |
| link | input | 1 | Carry/borrow/link bit that picks the single result |
| pair_mode | input | 1 | 1 = deliver both candidates, 0 = deliver the selected byte |
| res_pair | output | 16 | Candidate pair, or the zero-extended selected byte |
| res_sel | output | 8 | Candidate byte chosen by `link` |

## Verification
The hardest corners to reach are the wrap points. These are the carry out of the add at A+B=0xFF, the borrow when A equals B or is one less, and the 16-bit word increment carrying or the decrement borrowing across the byte boundary at 0x00FF, 0xFFFF and 0x0000. Random stimulus seldom hits them together with a given link value.

The stimulus sweeps every value of A against a fixed set of B corner values (0x00, 0x01, 0x02, 0x55, 0x7F, 0x80, 0xFE, 0xFF). This is done for every operation code and every combination of link and output mode. Each of those boundaries, and the unused codes, is therefore met deliberately under both selections.

// File: rtl/dra_pkg.sv
package dra_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_MNMX = 4'd3,
    OP_ORX  = 4'd4,
    OP_NRA  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9
  } dra_op_e;

  localparam int unsigned DRA_OP_W = 4;

endpackage

// File: rtl/dra_arith.sv
module dra_arith
  import dra_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [DRA_OP_W-1:0] op,
  input  logic [W-1:0]        opa,
  input  logic [W-1:0]        opb,
  output logic                hit,
  output logic [W-1:0]        cand_lo,
  output logic [W-1:0]        cand_hi
);

  localparam int unsigned DW = 2 * W;

  logic [W-1:0]  add_plain;
  logic [W-1:0]  add_carry;
  logic [W-1:0]  sub_plain;
  logic [W-1:0]  sub_borrow;
  logic [DW-1:0] product;
  logic [DW-1:0] word_in;
  logic [DW-1:0] word_up;
  logic [DW-1:0] word_dn;
  logic          a_below;
  logic [W-1:0]  smaller;
  logic [W-1:0]  larger;

  // both carry variants are formed side by side; no carry chain between them
  always_comb begin
    add_plain  = opa + opb;
    add_carry  = opa + opb + W'(1);
    sub_plain  = opa - opb;
    sub_borrow = opa - opb - W'(1);
  end

  always_comb begin
    product = DW'(opa) * DW'(opb);
  end

  always_comb begin
    a_below = (opa < opb);
    smaller = a_below ? opa : opb;
    larger  = a_below ? opb : opa;
  end

  // word view: B is the high byte, A the low byte
  always_comb begin
    word_in = {opb, opa};
    word_up = word_in + DW'(1);
    word_dn = word_in - DW'(1);
  end

  always_comb begin
    hit     = 1'b1;
    cand_lo = '0;
    cand_hi = '0;
    case (op)
      OP_ADD: begin
        cand_lo = add_plain;
        cand_hi = add_carry;
      end
      OP_SUB: begin
        cand_lo = sub_plain;
        cand_hi = sub_borrow;
      end
      OP_MUL: begin
        cand_lo = product[W-1:0];
        cand_hi = product[DW-1:W];
      end
      OP_MNMX: begin
        cand_lo = smaller;
        cand_hi = larger;
      end
      OP_INC: begin
        cand_lo = word_up[W-1:0];
        cand_hi = word_up[DW-1:W];
      end
      OP_DEC: begin
        cand_lo = word_dn[W-1:0];
        cand_hi = word_dn[DW-1:W];
      end
      default: begin
        hit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dra_bitwise.sv
module dra_bitwise
  import dra_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [DRA_OP_W-1:0] op,
  input  logic [W-1:0]        opa,
  input  logic [W-1:0]        opb,
  output logic                hit,
  output logic [W-1:0]        cand_lo,
  output logic [W-1:0]        cand_hi
);

  logic [W-1:0] v_or;
  logic [W-1:0] v_xor;
  logic [W-1:0] v_nor;
  logic [W-1:0] v_and;
  logic [W-1:0] shl_fill0;
  logic [W-1:0] shl_fill1;
  logic [W-1:0] shr_fill0;
  logic [W-1:0] shr_fill1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign v_or[i]  = opa[i] | opb[i];
    assign v_xor[i] = opa[i] ^ opb[i];
    assign v_nor[i] = ~(opa[i] | opb[i]);
    assign v_and[i] = opa[i] & opb[i];
  end

  for (genvar i = 0; i < W; i++) begin : g_shift
    if (i == 0) begin : g_lsb
      assign shl_fill0[i] = 1'b0;
      assign shl_fill1[i] = 1'b1;
    end else begin : g_mid_l
      assign shl_fill0[i] = opa[i-1];
      assign shl_fill1[i] = opa[i-1];
    end
    if (i == W - 1) begin : g_msb
      assign shr_fill0[i] = 1'b0;
      assign shr_fill1[i] = 1'b1;
    end else begin : g_mid_r
      assign shr_fill0[i] = opa[i+1];
      assign shr_fill1[i] = opa[i+1];
    end
  end

  always_comb begin
    hit     = 1'b1;
    cand_lo = '0;
    cand_hi = '0;
    case (op)
      OP_ORX: begin
        cand_lo = v_or;
        cand_hi = v_xor;
      end
      OP_NRA: begin
        cand_lo = v_nor;
        cand_hi = v_and;
      end
      OP_SHL: begin
        cand_lo = shl_fill0;
        cand_hi = shl_fill1;
      end
      OP_SHR: begin
        cand_lo = shr_fill0;
        cand_hi = shr_fill1;
      end
      default: begin
        hit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dra_outsel.sv
module dra_outsel #(
  parameter int unsigned W = 8
) (
  input  logic          ar_hit,
  input  logic [W-1:0]  ar_lo,
  input  logic [W-1:0]  ar_hi,
  input  logic          bw_hit,
  input  logic [W-1:0]  bw_lo,
  input  logic [W-1:0]  bw_hi,
  input  logic          link,
  input  logic          pair_mode,
  output logic [2*W-1:0] res_pair,
  output logic [W-1:0]  res_sel
);

  logic [W-1:0] lo_m;
  logic [W-1:0] hi_m;

  // the two units never claim the same code; an unclaimed code yields zero
  always_comb begin
    lo_m = '0;
    hi_m = '0;
    if (ar_hit) begin
      lo_m = ar_lo;
      hi_m = ar_hi;
    end else if (bw_hit) begin
      lo_m = bw_lo;
      hi_m = bw_hi;
    end
  end

  always_comb begin
    res_sel = link ? hi_m : lo_m;
    if (pair_mode) begin
      res_pair = {hi_m, lo_m};
    end else begin
      res_pair = {{W{1'b0}}, res_sel};
    end
  end

endmodule

// File: rtl/dual_result_alu.sv
module dual_result_alu
  import dra_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [DRA_OP_W-1:0] op,
  input  logic [W-1:0]        opa,
  input  logic [W-1:0]        opb,
  input  logic                link,
  input  logic                pair_mode,
  output logic [2*W-1:0]      res_pair,
  output logic [W-1:0]        res_sel
);

  logic         ar_hit;
  logic [W-1:0] ar_lo;
  logic [W-1:0] ar_hi;
  logic         bw_hit;
  logic [W-1:0] bw_lo;
  logic [W-1:0] bw_hi;

  dra_arith #(.W(W)) u_arith (
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .hit     (ar_hit),
    .cand_lo (ar_lo),
    .cand_hi (ar_hi)
  );

  dra_bitwise #(.W(W)) u_bitwise (
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .hit     (bw_hit),
    .cand_lo (bw_lo),
    .cand_hi (bw_hi)
  );

  dra_outsel #(.W(W)) u_outsel (
    .ar_hit    (ar_hit),
    .ar_lo     (ar_lo),
    .ar_hi     (ar_hi),
    .bw_hit    (bw_hit),
    .bw_lo     (bw_lo),
    .bw_hi     (bw_hi),
    .link      (link),
    .pair_mode (pair_mode),
    .res_pair  (res_pair),
    .res_sel   (res_sel)
  );

endmodule

// File: rtl/dra_checker.sv
module dra_checker
  import dra_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic [DRA_OP_W-1:0] op,
  input logic [W-1:0]        opa,
  input logic [W-1:0]        opb,
  input logic                link,
  input logic                pair_mode,
  input logic [2*W-1:0]      res_pair,
  input logic [W-1:0]        res_sel
);

  logic [W-1:0] p_hi;
  logic [W-1:0] p_lo;

  always_comb begin
    p_hi = res_pair[2*W-1:W];
    p_lo = res_pair[W-1:0];

    // R1: single mode carries only the selected byte
    if (!pair_mode) begin
      a_r1_single_zext: assert (p_hi == '0 && p_lo == res_sel)
        else $error("a_r1_single_zext");
    end

    // R2: the link picks one of the two delivered bytes
    if (pair_mode) begin
      a_r2_link_pick: assert (res_sel == (link ? p_hi : p_lo))
        else $error("a_r2_link_pick");
    end

    // R3: the carry-set sum is one above the carry-clear sum
    if (pair_mode && op == OP_ADD) begin
      a_r3_add_step: assert (p_hi == p_lo + W'(1))
        else $error("a_r3_add_step");
    end

    // R4: the borrow-set difference is one below the borrow-clear one
    if (pair_mode && op == OP_SUB) begin
      a_r4_sub_step: assert (p_lo == p_hi + W'(1))
        else $error("a_r4_sub_step");
    end

    // R6: ordered, and the pair is a permutation of the operands
    if (pair_mode && op == OP_MNMX) begin
      a_r6_order: assert (p_lo <= p_hi &&
                          ((p_lo == opa && p_hi == opb) || (p_lo == opb && p_hi == opa)))
        else $error("a_r6_order");
    end

    // R9: both shift variants differ only in the filled bit
    if (pair_mode && op == OP_SHL) begin
      a_r9_shl_fill: assert ((p_hi ^ p_lo) == W'(1))
        else $error("a_r9_shl_fill");
    end

    // R10: unused codes produce nothing
    if (op >= 4'd10) begin
      a_r10_unused_zero: assert (res_pair == '0 && res_sel == '0)
        else $error("a_r10_unused_zero");
    end
  end

endmodule

bind dual_result_alu dra_checker #(.W(W)) u_chk (
  .op        (op),
  .opa       (opa),
  .opb       (opb),
  .link      (link),
  .pair_mode (pair_mode),
  .res_pair  (res_pair),
  .res_sel   (res_sel)
);

// File: tb/dual_result_alu_tb.sv
module dual_result_alu_tb;

  localparam int unsigned W = 8;
  localparam int unsigned WATCHDOG = 150000;

  typedef struct {
    logic [3:0]  op;
    logic [7:0]  a;
    logic [7:0]  b;
    logic        lk;
    logic        pm;
    logic [15:0] exp_pair;
    logic [7:0]  exp_sel;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [7:0]  opa;
  logic [7:0]  opb;
  logic        link;
  logic        pair_mode;
  logic [15:0] res_pair;
  logic [7:0]  res_sel;

  item_t       sb_q[$];
  int          n_cmp;
  int          n_bad;
  int          cyc;
  bit          done;

  dual_result_alu #(.W(W)) u_dut (
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .link      (link),
    .pair_mode (pair_mode),
    .res_pair  (res_pair),
    .res_sel   (res_sel)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model: {high candidate, low candidate} per requirement
  function automatic logic [15:0] model_pair(logic [3:0] c, logic [7:0] a, logic [7:0] b);
    logic [15:0] w;
    w = {b, a};
    case (c)
      4'd0: return {8'(a + b + 8'd1), 8'(a + b)};             // R3
      4'd1: return {8'(a - b - 8'd1), 8'(a - b)};             // R4
      4'd2: return 16'(a) * 16'(b);                           // R5
      4'd3: return (a < b) ? {b, a} : {a, b};                 // R6
      4'd4: return {a ^ b, a | b};                            // R7
      4'd5: return {a & b, ~(a | b)};                         // R7
      4'd6: return w + 16'd1;                                 // R8
      4'd7: return w - 16'd1;                                 // R8
      4'd8: return {{a[6:0], 1'b1}, {a[6:0], 1'b0}};          // R9
      4'd9: return {{1'b1, a[7:1]}, {1'b0, a[7:1]}};          // R9
      default: return 16'h0000;                               // R10
    endcase
  endfunction

  function automatic string req_tag(logic [3:0] c);
    case (c)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(logic [3:0] c, logic [7:0] a, logic [7:0] b, logic lk, logic pm);
    item_t it;
    logic [15:0] cand;
    @(posedge clk);
    #1;
    op        = c;
    opa       = a;
    opb       = b;
    link      = lk;
    pair_mode = pm;
    cand        = model_pair(c, a, b);
    it.op       = c;
    it.a        = a;
    it.b        = b;
    it.lk       = lk;
    it.pm       = pm;
    it.exp_sel  = lk ? cand[15:8] : cand[7:0];               // R2
    it.exp_pair = pm ? cand : {8'h00, it.exp_sel};           // R1
    sb_q.push_back(it);
  endtask

  // monitor: compares away from the driving edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (res_pair !== it.exp_pair) begin
        n_bad++;
        $display("FAIL %s/R1 op=%0d a=%h b=%h link=%0b mode=%0b res_pair got %h exp %h",
                 req_tag(it.op), it.op, it.a, it.b, it.lk, it.pm, res_pair, it.exp_pair);
      end
      n_cmp++;
      if (res_sel !== it.exp_sel) begin
        n_bad++;
        $display("FAIL %s/R2 op=%0d a=%h b=%h link=%0b mode=%0b res_sel got %h exp %h",
                 req_tag(it.op), it.op, it.a, it.b, it.lk, it.pm, res_sel, it.exp_sel);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc >= WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] bset [8];
    bset[0] = 8'h00; bset[1] = 8'h01; bset[2] = 8'h02; bset[3] = 8'h55;
    bset[4] = 8'h7F; bset[5] = 8'h80; bset[6] = 8'hFE; bset[7] = 8'hFF;
    n_cmp = 0;
    n_bad = 0;
    cyc   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    op = 4'd0; opa = 8'h00; opb = 8'h00; link = 1'b0; pair_mode = 1'b1;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs: add of zeros, R3 boundary at operand zero
    drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b1);
    // directed corners: R3 wrap, R4 borrow, R8 byte carry, R10 unused
    drive(4'd0, 8'hFF, 8'h00, 1'b1, 1'b0);
    drive(4'd1, 8'h05, 8'h05, 1'b1, 1'b1);
    drive(4'd6, 8'hFF, 8'h00, 1'b0, 1'b1);
    drive(4'd6, 8'hFF, 8'hFF, 1'b1, 1'b0);
    drive(4'd7, 8'h00, 8'h00, 1'b0, 1'b1);
    drive(4'd7, 8'h00, 8'h01, 1'b1, 1'b1);
    drive(4'd2, 8'hFF, 8'hFF, 1'b1, 1'b1);
    drive(4'd15, 8'hAA, 8'h55, 1'b1, 1'b1);

    // sweep: every code, every A, B corners, all link/mode combinations
    for (int c = 0; c < 16; c++) begin
      for (int bi = 0; bi < 8; bi++) begin
        for (int a = 0; a < 256; a++) begin
          for (int lm = 0; lm < 4; lm++) begin
            drive(4'(c), 8'(a), bset[bi], lm[0], lm[1]);
          end
        end
      end
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule